// File: doc/BRIEF.md
# Widening Top-Element Shift-Left Unit

This block decodes one 32-bit instruction word for a signed, widening shift-left by immediate that reads only the top (odd-numbered) narrow elements of a source vector. It executes the instruction on a vector of fixed width, `VEC_W` bits, which defaults to 128. Each odd narrow element is taken as a signed value and sign-extended to twice its width. It is then shifted left by the immediate and truncated to the double width. The results are packed into double-width lanes in order, with lane e taken from narrow element 2e+1. There is no predicate, so every lane of a valid result is written.

The element size and the shift amount come from a single split field. A 3-bit size code is formed from bit 22 followed by bits 20:19. The 6-bit value {size code, bits 18:16} minus the element size gives the shift amount. The unit has a single cycle of latency. The word and vector present at one rising edge produce their result after that edge.

A registered output kind carries the decode result, and it has three states. KIND_IDLE means the word is not this instruction. KIND_EXEC means a valid result is present. KIND_UNDEF means the opcode matched but the size code is reserved. On every clock the next state is chosen from the current word alone. A mismatched word gives KIND_IDLE, a matched word with size code 000 gives KIND_UNDEF, and any other matched word gives KIND_EXEC. Any state can move to any other state in one clock. `VEC_W` must be a multiple of 64.

Top module: `slw_unit`

## Requirements
- R1: While rst_n is low, valid_o, undef_o, dst_o and result_o are all zero.
- R2: valid_o rises only for a word with all of the following: bits 31:24 = 8'h45, bit 23 = 0, bit 21 = 0, bits 15:12 = 4'b1010, bit 11 = 0, bit 10 = 1, and a nonzero size code. Any other word gives valid_o = 0, undef_o = 0 and result_o = 0.
- R3: A word that matches the R2 opcode bits but has size code {bit 22, bits 20:19} = 3'b000 gives undef_o = 1, valid_o = 0 and result_o = 0. valid_o and undef_o are never high together.
- R4: The size code selects the element size: 3'b001 selects 8 bits, 3'b01x selects 16 bits and 3'b1xx selects 32 bits.
- R5: The shift amount is the unsigned value of {size code, bits 18:16} minus the element size. It covers 0 up to the element size minus 1.
- R6: Result lane e (of width 2·esize, at bit e·2·esize) comes from narrow source element 2e+1. Even-numbered source elements have no effect on result_o.
- R7: Each selected element is sign-extended to 2·esize bits, shifted left and truncated to 2·esize bits. All VEC_W/(2·esize) lanes are written.
- R8: dst_o carries bits 4:0 of the word whenever valid_o or undef_o is high, and it is zero otherwise.
- R9: The outputs change only on a rising clock edge. They reflect the word and vector that were present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| src_i | input | VEC_W | Source vector value |
| dst_o | output | 5 | Destination register index |
| result_o | output | VEC_W | Packed double-width results |
| valid_o | output | 1 | Word decoded as this instruction with a legal size |
| undef_o | output | 1 | Word matched but its size code is reserved |

## Verification
A wrong output kind shows up one cycle after the offending word, as a wrong valid_o or undef_o. It can also show up as a nonzero result_o that sits beside a low valid_o. A wrong element size or shift in the decode does not stay local: it misplaces every lane of result_o in that same cycle. The clearest exposure comes from the most negative and most positive element values at shifts 0 and esize-1. Swapping even and odd elements shows up as soon as the two element sets hold different values.

// File: rtl/slw_pkg.sv
package slw_pkg;

    typedef enum logic [1:0] {
        ESZ_8,
        ESZ_16,
        ESZ_32
    } esz_e;

    typedef enum logic [1:0] {
        KIND_IDLE,
        KIND_EXEC,
        KIND_UNDEF
    } kind_e;

    localparam logic [7:0] MAJOR_OP   = 8'h45;
    localparam logic [3:0] MINOR_OP   = 4'b1010;
    localparam int         NUM_SIZES  = 3;
    localparam int         BASE_ESIZE = 8;

endpackage

// File: rtl/slw_decode.sv
module slw_decode
    import slw_pkg::*;
(
    input  logic [31:0] insn_i,
    output logic        match_o,
    output logic        code_zero_o,
    output esz_e        esz_o,
    output logic [4:0]  shift_o,
    output logic [4:0]  rd_o
);

    logic [2:0] size_code;
    logic [5:0] imm6;
    logic [5:0] base;
    logic [5:0] diff;
    logic       unused_dec;

    assign size_code = {insn_i[22], insn_i[20:19]};
    assign imm6      = {size_code, insn_i[18:16]};

    assign match_o = (insn_i[31:24] == MAJOR_OP) && !insn_i[23] && !insn_i[21]
                   && (insn_i[15:12] == MINOR_OP) && !insn_i[11] && insn_i[10];

    assign code_zero_o = (size_code == 3'b000);
    assign rd_o        = insn_i[4:0];

    always_comb begin
        if (size_code[2]) begin
            esz_o = ESZ_32;
            base  = 6'd32;
        end else if (size_code[1]) begin
            esz_o = ESZ_16;
            base  = 6'd16;
        end else begin
            esz_o = ESZ_8;
            base  = 6'd8;
        end
    end

    assign diff    = imm6 - base;
    assign shift_o = diff[4:0];

    assign unused_dec = ^{diff[5], insn_i[9:5]};

endmodule

// File: rtl/slw_lane_bank.sv
module slw_lane_bank #(
    parameter int VEC_W = 128,
    parameter int ESZ   = 8
) (
    input  logic [VEC_W-1:0] src_i,
    input  logic [4:0]       shift_i,
    output logic [VEC_W-1:0] res_o
);

    localparam int WIDE  = 2 * ESZ;
    localparam int LANES = VEC_W / WIDE;

    logic [LANES-1:0] even_par;
    logic             unused_even;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [ESZ-1:0]  narrow;
        logic [WIDE-1:0] ext;

        assign narrow      = src_i[(2*e+1)*ESZ +: ESZ];
        assign ext         = {{ESZ{narrow[ESZ-1]}}, narrow};
        assign res_o[e*WIDE +: WIDE] = ext << shift_i;
        assign even_par[e] = ^src_i[(2*e)*ESZ +: ESZ];
    end

    assign unused_even = ^even_par;

endmodule

// File: rtl/slw_unit.sv
module slw_unit
    import slw_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      insn_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [4:0]       dst_o,
    output logic [VEC_W-1:0] result_o,
    output logic             valid_o,
    output logic             undef_o
);

    logic       dec_match;
    logic       dec_code_zero;
    esz_e       dec_esz;
    logic [4:0] dec_shift;
    logic [4:0] dec_rd;

    logic [VEC_W-1:0] bank_res [NUM_SIZES];
    logic [VEC_W-1:0] sel_res;

    kind_e            kind_q;
    kind_e            kind_d;
    logic [VEC_W-1:0] result_q;
    logic [4:0]       dst_q;

    slw_decode u_decode (
        .insn_i      (insn_i),
        .match_o     (dec_match),
        .code_zero_o (dec_code_zero),
        .esz_o       (dec_esz),
        .shift_o     (dec_shift),
        .rd_o        (dec_rd)
    );

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_bank
        slw_lane_bank #(
            .VEC_W (VEC_W),
            .ESZ   (BASE_ESIZE << gi)
        ) u_bank (
            .src_i   (src_i),
            .shift_i (dec_shift),
            .res_o   (bank_res[gi])
        );
    end

    always_comb begin
        unique case (dec_esz)
            ESZ_8:   sel_res = bank_res[0];
            ESZ_16:  sel_res = bank_res[1];
            ESZ_32:  sel_res = bank_res[2];
            default: sel_res = '0;
        endcase
    end

    always_comb begin
        if (!dec_match) begin
            kind_d = KIND_IDLE;
        end else if (dec_code_zero) begin
            kind_d = KIND_UNDEF;
        end else begin
            kind_d = KIND_EXEC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= KIND_IDLE;
        end else begin
            kind_q <= kind_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            dst_q    <= '0;
        end else begin
            unique case (kind_d)
                KIND_EXEC: begin
                    result_q <= sel_res;
                    dst_q    <= dec_rd;
                end
                KIND_UNDEF: begin
                    result_q <= '0;
                    dst_q    <= dec_rd;
                end
                default: begin
                    result_q <= '0;
                    dst_q    <= '0;
                end
            endcase
        end
    end

    assign valid_o  = (kind_q == KIND_EXEC);
    assign undef_o  = (kind_q == KIND_UNDEF);
    assign result_o = result_q;
    assign dst_o    = dst_q;

endmodule

// File: rtl/slw_unit_chk.sv
module slw_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      insn_i,
    input logic [4:0]       dst_o,
    input logic [VEC_W-1:0] result_o,
    input logic             valid_o,
    input logic             undef_o
);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (!valid_o && !undef_o && dst_o == 5'd0 && result_o == '0));

    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && undef_o));

    assert_undef_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (result_o == '0));

    assert_undef_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> ($past({insn_i[22], insn_i[20:19]}) == 3'b000));

    assert_quiet_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (result_o == '0));

    assert_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(insn_i[31:21]) != 11'h0 && $past(insn_i[31:24]) == 8'h45
                     && $past(insn_i[15:10]) == 6'b101001
                     && $past({insn_i[22], insn_i[20:19]}) != 3'b000));

    assert_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || undef_o) |-> (dst_o == $past(insn_i[4:0])));

    assert_idle_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o || undef_o) |-> (dst_o == 5'd0));

endmodule

bind slw_unit slw_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .insn_i   (insn_i),
    .dst_o    (dst_o),
    .result_o (result_o),
    .valid_o  (valid_o),
    .undef_o  (undef_o)
);

// File: tb/slw_unit_tb.sv
module slw_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int VW         = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   insn = '0;
    logic [VW-1:0] src = '0;
    logic [4:0]    dst;
    logic [VW-1:0] result;
    logic          valid;
    logic          undef;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slw_unit #(.VEC_W(VW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .insn_i   (insn),
        .src_i    (src),
        .dst_o    (dst),
        .result_o (result),
        .valid_o  (valid),
        .undef_o  (undef)
    );

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] code, input logic [2:0] imm3, input logic [4:0] rn, input logic [4:0] rd);
        return {8'h45, 1'b0, code[2], 1'b0, code[1:0], imm3, 4'b1010, 1'b0, 1'b1, rn, rd};
    endfunction

    function automatic logic [31:0] mk_sh(input int es, input int sh, input logic [4:0] rd);
        logic [5:0] imm6;
        imm6 = 6'(es + sh);
        return mk(imm6[5:3], imm6[2:0], 5'd3, rd);
    endfunction

    function automatic logic [VW-1:0] model(input logic [31:0] w, input logic [VW-1:0] s);
        logic [2:0]    code;
        logic [VW-1:0] r;
        int            es;
        int            sh;
        r = '0;
        code = {w[22], w[20:19]};
        if (w[31:24] != 8'h45 || w[23] || w[21] || w[15:12] != 4'b1010 || w[11] || !w[10])
            return '0;
        if (code == 3'b000)
            return '0;
        es = code[2] ? 32 : (code[1] ? 16 : 8);
        sh = int'({code, w[18:16]}) - es;
        for (int e = 0; e < VW / (2 * es); e++) begin
            logic signed [63:0] v;
            v = '0;
            for (int b = 0; b < es; b++) v[b] = s[(2*e+1)*es + b];
            v = (v <<< (64 - es)) >>> (64 - es);
            v = v <<< sh;
            for (int b = 0; b < 2 * es; b++) r[e*2*es + b] = v[b];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] fill(input int es, input logic [31:0] odd_v, input logic [31:0] even_v);
        logic [VW-1:0] s;
        s = '0;
        for (int i = 0; i < VW / es; i++)
            for (int b = 0; b < es; b++)
                s[i*es + b] = (i % 2 == 1) ? odd_v[b] : even_v[b];
        return s;
    endfunction

    task automatic run(input logic [31:0] w, input logic [VW-1:0] s);
        @(negedge clk);
        insn = w;
        src  = s;
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", VW'(valid), '0);
        check("R1 undef in reset", VW'(undef), '0);
        check("R1 dst in reset", VW'(dst), '0);
        check("R1 result in reset", result, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_extremes;
        for (int k = 0; k < 3; k++) begin
            int es;
            logic [31:0] mneg;
            logic [31:0] mpos;
            es = 8 << k;
            mneg = 32'h1 << (es - 1);
            mpos = mneg - 32'd1;
            for (int q = 0; q < 2; q++) begin
                int sh;
                logic [31:0] w;
                sh = (q == 0) ? 0 : es - 1;
                w = mk_sh(es, sh, 5'd17);
                run(w, fill(es, mneg, mpos));
                check($sformatf("R7 R5 R4 es%0d sh%0d min", es, sh), result, model(w, fill(es, mneg, mpos)));
                check("R2 valid on legal word", VW'(valid), VW'(1));
                run(w, fill(es, mpos, mneg));
                check($sformatf("R7 R5 R4 es%0d sh%0d max", es, sh), result, model(w, fill(es, mpos, mneg)));
            end
        end
        run(mk_sh(8, 7, 5'd1), {(VW/8){8'h80}});
        check("R7 hand value 8-bit min shifted 7", result, {(VW/16){16'hC000}});
        run(mk_sh(32, 31, 5'd1), {(VW/32){32'h7FFF_FFFF}});
        check("R7 hand value 32-bit max shifted 31", result, {(VW/64){64'h3FFF_FFFF_8000_0000}});
    endtask

    task automatic t_even_ignored;
        logic [VW-1:0] a;
        logic [VW-1:0] first;
        for (int k = 0; k < 3; k++) begin
            int es;
            es = 8 << k;
            a = fill(es, 32'h5A3C_96E1, 32'h0000_0000);
            run(mk_sh(es, 3, 5'd9), a);
            first = result;
            check($sformatf("R6 odd elements es%0d", es), first, model(mk_sh(es, 3, 5'd9), a));
            run(mk_sh(es, 3, 5'd9), fill(es, 32'h5A3C_96E1, 32'hFFFF_FFFF));
            check($sformatf("R6 even elements no effect es%0d", es), result, first);
        end
    endtask

    task automatic t_patterns;
        logic [VW-1:0] s;
        s = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hF00D_CAFE};
        for (int k = 0; k < 3; k++) begin
            int es;
            es = 8 << k;
            for (int sh = 1; sh < es; sh += 5) begin
                run(mk_sh(es, sh, 5'(sh)), s);
                check($sformatf("R5 R6 R7 pattern es%0d sh%0d", es, sh), result, model(mk_sh(es, sh, 5'(sh)), s));
            end
        end
        run(mk(3'b011, 3'b111, 5'd0, 5'd2), s);
        check("R4 code 01x gives 16-bit sh 15", result, model(mk(3'b011, 3'b111, 5'd0, 5'd2), s));
    endtask

    task automatic t_undef;
        for (int i = 0; i < 8; i += 7) begin
            run(mk(3'b000, 3'(i), 5'd4, 5'd22), {(VW/8){8'h81}});
            check("R3 undef set", VW'(undef), VW'(1));
            check("R3 valid clear on undef", VW'(valid), '0);
            check("R3 result zero on undef", result, '0);
            check("R8 dst on undef", VW'(dst), VW'(22));
        end
    endtask

    task automatic t_bad;
        logic [31:0] good;
        int bits [14] = '{31, 30, 29, 28, 27, 26, 25, 24, 23, 21, 15, 14, 11, 10};
        good = mk_sh(16, 4, 5'd30);
        foreach (bits[i]) begin
            logic [31:0] w;
            w = good ^ (32'h1 << bits[i]);
            run(w, {(VW/8){8'hC3}});
            check($sformatf("R2 bit %0d flipped valid", bits[i]), VW'(valid), '0);
            check($sformatf("R2 bit %0d flipped result", bits[i]), result, '0);
            check($sformatf("R8 bit %0d flipped dst", bits[i]), VW'(dst) | VW'(undef), '0);
        end
    endtask

    task automatic t_latency;
        logic [31:0] wa;
        logic [31:0] wb;
        logic [VW-1:0] sa;
        wa = mk_sh(8, 2, 5'd5);
        wb = mk_sh(32, 9, 5'd12);
        sa = fill(8, 32'h7F, 32'h01);
        run(wa, sa);
        check("R8 dst after word A", VW'(dst), VW'(5));
        insn = wb;
        src  = fill(32, 32'h8000_0001, 32'h0);
        #(CLK_PERIOD/4);
        check("R9 output holds before edge", result, model(wa, sa));
        @(negedge clk);
        check("R9 output after edge", result, model(wb, fill(32, 32'h8000_0001, 32'h0)));
        check("R8 dst after word B", VW'(dst), VW'(12));
    endtask

    initial begin
        t_reset();
        t_extremes();
        t_even_ignored();
        t_patterns();
        t_undef();
        t_bad();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule